// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Aspect Ratio

This block is a synchronous memory of 4608 bits with two independent ports, A and B. Each port has its own clock, enable, write enable, 12-bit address, 9-bit write data and 9-bit read data. A 2-bit shape code on each port selects how that port sees the array: a 4096-deep column of single bits, 2048 pairs, 1024 nibbles or 512 nine-bit words. The two ports may use different shapes at the same time and see consistent data. In the narrow shapes the low address bits pick a lane within bits 7..0 of a nine-bit word, with lane 0 at the least significant end.

Each port also has two output controls. The first adds an extra output register stage. The second decides whether a write shows the written value on the output or leaves the last read value in place. A shared active-low reset clears both outputs at once and leaves the stored contents alone.

Top module: `dpram_aspect`

## Requirements
- R1: Shape code 2'b00 gives 1 bit by 4096, 2'b01 gives 2 bits by 2048, 2'b10 gives 4 bits by 1024 and 2'b11 gives 9 bits by 512. Data sits in the low bits of the data buses, and output bits above the chosen width are undefined.
- R2: In the 1, 2 and 4-bit shapes, address a maps to word a>>(3-log2(w)), bits starting at lane*w, where lane = a mod (8/w). A nine-bit port at that word reads the same bits.
- R3: Address bits above the chosen depth are ignored: bit 11 for 2048, bits 11..10 for 1024, bits 11..9 for 512.
- R4: Write data bits above the chosen width are ignored, and a narrow write leaves every other bit of the word unchanged.
- R5: While a port's enable (active low) is high, that port neither reads nor writes, and its output holds.
- R6: With the enable low, a low write enable writes on the rising clock edge, and a high write enable reads.
- R7: With the pipeline select low, read data is on the output right after the reading edge. With it high, the data appears one clock later.
- R8: During a write with the write-mode select low, the output keeps the last read value.
- R9: During a write with the write-mode select high, the written data (low bits of the chosen width) is on the output after the writing edge.
- R10: The write-mode select has no effect on reads.
- R11: A low reset forces both outputs to zero without waiting for a clock edge, and stored data survives it.
- R12: Each port works on its own clock. Data written through one port can be read through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low clear of both outputs |
| clk_a | input | 1 | Port A clock |
| en_n_a | input | 1 | Port A enable, active low |
| we_n_a | input | 1 | Port A write enable, active low |
| width_a | input | 2 | Port A shape code |
| pipe_a | input | 1 | Port A extra output register select |
| wthru_a | input | 1 | Port A write-through select |
| addr_a | input | 12 | Port A address |
| din_a | input | 9 | Port A write data |
| dout_a | output | 9 | Port A read data |
| clk_b | input | 1 | Port B clock |
| en_n_b | input | 1 | Port B enable, active low |
| we_n_b | input | 1 | Port B write enable, active low |
| width_b | input | 2 | Port B shape code |
| pipe_b | input | 1 | Port B extra output register select |
| wthru_b | input | 1 | Port B write-through select |
| addr_b | input | 12 | Port B address |
| din_b | input | 9 | Port B write data |
| dout_b | output | 9 | Port B read data |

## Verification
The bench writes through one port in a narrow shape and reads through the other in another shape. A wrong lane mapping would return bits from the wrong word or the wrong position. It sets high address bits and high data bits that must be ignored, which exposes a decoder that aliases to a different word or a write that spills into bit 8 or into a neighbouring lane. It also catches an output that changes while the port is disabled or during a hold-mode write, a pipeline stage that is skipped or doubled, and a reset that waits for a clock or wipes the stored data.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;
  localparam int WORD_W = 9;
  localparam int SH_W   = 4;

  typedef enum logic [1:0] {
    SHP_X1 = 2'b00,
    SHP_X2 = 2'b01,
    SHP_X4 = 2'b10,
    SHP_X9 = 2'b11
  } shape_e;

  function automatic logic [WORD_W-1:0] shape_mask(shape_e s);
    case (s)
      SHP_X1:  return WORD_W'(4'h1);
      SHP_X2:  return WORD_W'(4'h3);
      SHP_X4:  return WORD_W'(4'hF);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/dpr_addr_map.sv
`timescale 1ns/1ps
module dpr_addr_map
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        shape,
  input  logic [WORD_W-1:0] din,
  output logic [IDX_W-1:0]  word_idx,
  output logic [SH_W-1:0]   lane_sh,
  output logic [WORD_W-1:0] lane_mask,
  output logic [WORD_W-1:0] wr_aligned
);
  shape_e            sel;
  logic [WORD_W-1:0] base_mask;

  assign sel = shape_e'(shape);

  always_comb begin
    base_mask = shape_mask(sel);
    unique case (sel)
      SHP_X1: begin
        word_idx = addr[IDX_W+2:3];
        lane_sh  = SH_W'(addr[2:0]);
      end
      SHP_X2: begin
        word_idx = addr[IDX_W+1:2];
        lane_sh  = SH_W'({addr[1:0], 1'b0});
      end
      SHP_X4: begin
        word_idx = addr[IDX_W:1];
        lane_sh  = SH_W'({addr[0], 2'b00});
      end
      default: begin
        word_idx = addr[IDX_W-1:0];
        lane_sh  = '0;
      end
    endcase
    lane_mask  = base_mask << lane_sh;
    wr_aligned = (din & base_mask) << lane_sh;
  end
endmodule

// File: rtl/dpr_bank.sv
`timescale 1ns/1ps
module dpr_bank
  import dpr_pkg::*;
#(
  parameter int IDX_W   = 9,
  parameter bit TAG_INV = 1'b0,
  localparam int WORDS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [WORD_W-1:0] w_mask,
  input  logic [WORD_W-1:0] w_data,
  input  logic [WORD_W-1:0] peer_tag,
  input  logic [IDX_W-1:0]  r0_idx,
  input  logic [IDX_W-1:0]  r1_idx,
  output logic [WORD_W-1:0] r0_data,
  output logic [WORD_W-1:0] r0_tag,
  output logic [WORD_W-1:0] r1_data,
  output logic [WORD_W-1:0] r1_tag
);
  logic [WORD_W-1:0] data_q [WORDS];
  logic [WORD_W-1:0] tag_q  [WORDS];
  logic [WORD_W-1:0] tag_new;

  // Bank A marks its bits as newest by making its tag differ from the
  // peer's; bank B marks them by making its tag equal to the peer's.
  assign tag_new = peer_tag ^ {WORD_W{TAG_INV}};

  always_ff @(posedge clk) begin
    if (we) begin
      data_q[w_idx] <= (data_q[w_idx] & ~w_mask) | (w_data & w_mask);
      tag_q[w_idx]  <= (tag_q[w_idx]  & ~w_mask) | (tag_new & w_mask);
    end
  end

  assign r0_data = data_q[r0_idx];
  assign r0_tag  = tag_q[r0_idx];
  assign r1_data = data_q[r1_idx];
  assign r1_tag  = tag_q[r1_idx];
endmodule

// File: rtl/dpr_port_out.sv
`timescale 1ns/1ps
module dpr_port_out
  import dpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              we_n,
  input  logic              pipe,
  input  logic              wthru,
  input  logic [1:0]        shape,
  input  logic [SH_W-1:0]   lane_sh,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] wmask, rd_val, wr_val, stage1, stage2;
  logic              do_rd, do_wr;

  assign do_rd = !en_n && we_n;
  assign do_wr = !en_n && !we_n;

  always_comb begin
    wmask  = shape_mask(shape_e'(shape));
    rd_val = (rd_word >> lane_sh) & wmask;
    wr_val = din & wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
    end else if (do_rd) begin
      stage1 <= rd_val;
    end else if (do_wr && wthru) begin
      stage1 <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage2 <= '0;
    else        stage2 <= stage1;
  end

  assign dout = pipe ? stage2 : stage1;

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(stage1));

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !we_n && !wthru) |=> $stable(stage1));

  assert_write_thru_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && !we_n && wthru) |=> (stage1 == $past(din & wmask)));

  assert_pipe_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage2 == $past(stage1));

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rst_n |-> (dout == '0));
endmodule

// File: rtl/dpram_aspect.sv
`timescale 1ns/1ps
module dpram_aspect
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              rst_n,
  input  logic              clk_a,
  input  logic              en_n_a,
  input  logic              we_n_a,
  input  logic [1:0]        width_a,
  input  logic              pipe_a,
  input  logic              wthru_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [WORD_W-1:0] din_a,
  output logic [WORD_W-1:0] dout_a,
  input  logic              clk_b,
  input  logic              en_n_b,
  input  logic              we_n_b,
  input  logic [1:0]        width_b,
  input  logic              pipe_b,
  input  logic              wthru_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [WORD_W-1:0] din_b,
  output logic [WORD_W-1:0] dout_b
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int NPORT = 2;

  logic [NPORT-1:0]  clk_v, en_v, we_v, pipe_v, thru_v, wr_v;
  logic [1:0]        shp_v  [NPORT];
  logic [ADDR_W-1:0] addr_v [NPORT];
  logic [WORD_W-1:0] din_v  [NPORT];
  logic [WORD_W-1:0] dout_v [NPORT];
  logic [IDX_W-1:0]  idx_v  [NPORT];
  logic [SH_W-1:0]   sh_v   [NPORT];
  logic [WORD_W-1:0] mask_v [NPORT];
  logic [WORD_W-1:0] wdat_v [NPORT];
  logic [WORD_W-1:0] rword_v[NPORT];
  // bank p read at port q lives at index p*NPORT+q
  logic [WORD_W-1:0] bk_data [NPORT*NPORT];
  logic [WORD_W-1:0] bk_tag  [NPORT*NPORT];

  assign clk_v  = {clk_b, clk_a};
  assign en_v   = {en_n_b, en_n_a};
  assign we_v   = {we_n_b, we_n_a};
  assign pipe_v = {pipe_b, pipe_a};
  assign thru_v = {wthru_b, wthru_a};
  assign shp_v[0]  = width_a;
  assign shp_v[1]  = width_b;
  assign addr_v[0] = addr_a;
  assign addr_v[1] = addr_b;
  assign din_v[0]  = din_a;
  assign din_v[1]  = din_b;
  assign dout_a    = dout_v[0];
  assign dout_b    = dout_v[1];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [WORD_W-1:0] newer_a;

    assign wr_v[p] = !en_v[p] && !we_v[p];

    dpr_addr_map #(.ADDR_W(ADDR_W)) u_map (
      .addr      (addr_v[p]),
      .shape     (shp_v[p]),
      .din       (din_v[p]),
      .word_idx  (idx_v[p]),
      .lane_sh   (sh_v[p]),
      .lane_mask (mask_v[p]),
      .wr_aligned(wdat_v[p])
    );

    dpr_bank #(.IDX_W(IDX_W), .TAG_INV(p == 0 ? 1'b1 : 1'b0)) u_bank (
      .clk     (clk_v[p]),
      .we      (wr_v[p]),
      .w_idx   (idx_v[p]),
      .w_mask  (mask_v[p]),
      .w_data  (wdat_v[p]),
      .peer_tag(bk_tag[(1-p)*NPORT+p]),
      .r0_idx  (idx_v[0]),
      .r1_idx  (idx_v[1]),
      .r0_data (bk_data[p*NPORT]),
      .r0_tag  (bk_tag[p*NPORT]),
      .r1_data (bk_data[p*NPORT+1]),
      .r1_tag  (bk_tag[p*NPORT+1])
    );

    // a differing tag bit means bank A holds the newest copy of that bit
    assign newer_a    = bk_tag[p] ^ bk_tag[NPORT+p];
    assign rword_v[p] = (bk_data[p] & newer_a) | (bk_data[NPORT+p] & ~newer_a);

    dpr_port_out u_out (
      .clk    (clk_v[p]),
      .rst_n  (rst_n),
      .en_n   (en_v[p]),
      .we_n   (we_v[p]),
      .pipe   (pipe_v[p]),
      .wthru  (thru_v[p]),
      .shape  (shp_v[p]),
      .lane_sh(sh_v[p]),
      .rd_word(rword_v[p]),
      .din    (din_v[p]),
      .dout   (dout_v[p])
    );
  end
endmodule

// File: tb/tb_dpram_aspect.sv
`timescale 1ns/1ps
module tb_dpram_aspect;
  logic       rst_n = 1'b0;
  logic       clk_a = 1'b0, clk_b = 1'b0;
  logic       en_n_a = 1'b1, we_n_a = 1'b1, pipe_a = 1'b0, wthru_a = 1'b0;
  logic       en_n_b = 1'b1, we_n_b = 1'b1, pipe_b = 1'b0, wthru_b = 1'b0;
  logic [1:0] width_a = 2'b11, width_b = 2'b11;
  logic [11:0] addr_a = '0, addr_b = '0;
  logic [8:0] din_a = '0, din_b = '0;
  logic [8:0] dout_a, dout_b;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #2 clk_a = ~clk_a;   // 250 MHz
  always #3 clk_b = ~clk_b;   // unrelated second clock

  dpram_aspect dut (
    .rst_n(rst_n),
    .clk_a(clk_a), .en_n_a(en_n_a), .we_n_a(we_n_a), .width_a(width_a),
    .pipe_a(pipe_a), .wthru_a(wthru_a), .addr_a(addr_a), .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk_b), .en_n_b(en_n_b), .we_n_b(we_n_b), .width_b(width_b),
    .pipe_b(pipe_b), .wthru_b(wthru_b), .addr_b(addr_b), .din_b(din_b), .dout_b(dout_b)
  );

  function automatic logic [8:0] wmask(input logic [1:0] w);
    case (w)
      2'b00:   return 9'h001;
      2'b01:   return 9'h003;
      2'b10:   return 9'h00F;
      default: return 9'h1FF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp,
                     input logic [8:0] m);
    n_chk++;
    if ((act & m) !== (exp & m)) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (mask %h)", req, act & m, exp & m, m);
    end
  endtask

  task automatic tick(input int p);
    if (p == 0) @(negedge clk_a);
    else        @(negedge clk_b);
  endtask

  // one port cycle: drive at a falling edge, return at the next falling edge
  task automatic op(input int p, input bit act, input bit wr, input logic [11:0] ad,
                    input logic [8:0] d, input logic [1:0] w, input bit pp, input bit wt);
    tick(p);
    if (p == 0) begin
      en_n_a = !act; we_n_a = !wr; addr_a = ad; din_a = d;
      width_a = w; pipe_a = pp; wthru_a = wt;
    end else begin
      en_n_b = !act; we_n_b = !wr; addr_b = ad; din_b = d;
      width_b = w; pipe_b = pp; wthru_b = wt;
    end
    tick(p);
    if (p == 0) en_n_a = 1'b1;
    else        en_n_b = 1'b1;
  endtask

  function automatic logic [8:0] dout_of(input int p);
    return (p == 0) ? dout_a : dout_b;
  endfunction

  task automatic wr(input int p, input logic [1:0] w, input logic [11:0] ad,
                    input logic [8:0] d);
    op(p, 1, 1, ad, d, w, 0, 0);
  endtask

  task automatic rd(input int p, input logic [1:0] w, input logic [11:0] ad,
                    input bit wt, output logic [8:0] v);
    op(p, 1, 0, ad, 9'h000, w, 0, wt);
    v = dout_of(p);
  endtask

  task automatic t_reset_state;
    chk("R11 reset A", dout_a, 9'h000, 9'h1FF);
    chk("R11 reset B", dout_b, 9'h000, 9'h1FF);
  endtask

  task automatic t_full_width;
    logic [8:0] v;
    wr(0, 2'b11, 12'h005, 9'h1A5);
    wr(0, 2'b11, 12'h1FF, 9'h0F3);
    rd(0, 2'b11, 12'h005, 0, v); chk("R1 R6 x9 word 5", v, 9'h1A5, 9'h1FF);
    rd(0, 2'b11, 12'h1FF, 0, v); chk("R1 R6 x9 word 511", v, 9'h0F3, 9'h1FF);
  endtask

  task automatic t_narrow_mix;
    logic [8:0] v;
    logic [7:0] pat = 8'b1011_0010;
    for (int i = 0; i < 8; i++) wr(0, 2'b00, 12'(16 + i), {8'h00, pat[i]});
    rd(1, 2'b11, 12'h002, 0, v); chk("R2 R12 x1 bits seen by x9", v, 9'h0B2, 9'h0FF);
    rd(0, 2'b00, 12'd21, 0, v);  chk("R1 x1 read bit", v, 9'h001, 9'h001);
    wr(1, 2'b01, 12'd28, 9'h001);
    wr(1, 2'b01, 12'd29, 9'h002);
    wr(1, 2'b01, 12'd30, 9'h003);
    wr(1, 2'b01, 12'd31, 9'h000);
    rd(0, 2'b10, 12'd14, 0, v); chk("R2 x2 lanes seen by x4 lo", v, 9'h009, 9'h00F);
    rd(0, 2'b10, 12'd15, 0, v); chk("R2 x2 lanes seen by x4 hi", v, 9'h003, 9'h00F);
    rd(0, 2'b11, 12'd7, 0, v);  chk("R2 x2 lanes seen by x9", v, 9'h039, 9'h0FF);
  endtask

  task automatic t_addr_high;
    logic [8:0] v;
    wr(0, 2'b01, 12'h80D, 9'h002);
    rd(1, 2'b01, 12'h00D, 0, v); chk("R3 x2 bit11 ignored", v, 9'h002, 9'h003);
    wr(0, 2'b10, 12'hC07, 9'h00A);
    rd(1, 2'b10, 12'h007, 0, v); chk("R3 x4 bits11:10 ignored", v, 9'h00A, 9'h00F);
    wr(0, 2'b11, 12'hE40, 9'h155);
    rd(1, 2'b11, 12'h040, 0, v); chk("R3 x9 bits11:9 ignored", v, 9'h155, 9'h1FF);
  endtask

  task automatic t_din_high;
    logic [8:0] v;
    wr(0, 2'b11, 12'd9, 9'h0A0);
    wr(0, 2'b10, 12'd18, 9'h1F5);
    rd(1, 2'b11, 12'd9, 0, v); chk("R4 x4 high data ignored", v, 9'h0A5, 9'h1FF);
    wr(0, 2'b00, 12'd79, 9'h1FE);
    rd(1, 2'b11, 12'd9, 0, v); chk("R4 x1 writes lane 7 only", v, 9'h025, 9'h1FF);
  endtask

  task automatic t_enable;
    logic [8:0] v;
    rd(0, 2'b11, 12'h005, 0, v); chk("R6 read before idle", v, 9'h1A5, 9'h1FF);
    op(0, 0, 1, 12'h005, 9'h000, 2'b11, 0, 1);
    chk("R5 idle write keeps output", dout_a, 9'h1A5, 9'h1FF);
    op(0, 0, 0, 12'h1FF, 9'h000, 2'b11, 0, 0);
    chk("R5 idle read keeps output", dout_a, 9'h1A5, 9'h1FF);
    rd(1, 2'b11, 12'h005, 0, v); chk("R5 idle write stored nothing", v, 9'h1A5, 9'h1FF);
  endtask

  task automatic t_pipe;
    logic [8:0] v;
    rd(0, 2'b11, 12'h1FF, 0, v); chk("R7 unpipelined read", v, 9'h0F3, 9'h1FF);
    op(0, 1, 0, 12'h005, 9'h000, 2'b11, 1, 0);
    chk("R7 piped: old value after read edge", dout_a, 9'h0F3, 9'h1FF);
    tick(0);
    chk("R7 piped: new value one clock later", dout_a, 9'h1A5, 9'h1FF);
    op(0, 0, 0, 12'h000, 9'h000, 2'b11, 0, 0);
  endtask

  task automatic t_write_modes;
    logic [8:0] v;
    rd(0, 2'b11, 12'h005, 0, v);
    op(0, 1, 1, 12'h006, 9'h033, 2'b11, 0, 0);
    chk("R8 hold write keeps last read", dout_a, 9'h1A5, 9'h1FF);
    rd(0, 2'b11, 12'h006, 1, v); chk("R10 read with write-through set", v, 9'h033, 9'h1FF);
    rd(0, 2'b11, 12'h005, 0, v); chk("R10 read with write-through clear", v, 9'h1A5, 9'h1FF);
    op(0, 1, 1, 12'd14, 9'h01C, 2'b10, 0, 1);
    chk("R9 write-through shows data", dout_a, 9'h00C, 9'h00F);
    rd(1, 2'b11, 12'd7, 0, v); chk("R9 write-through data stored", v, 9'h03C, 9'h0FF);
  endtask

  task automatic t_reset_mid;
    logic [8:0] v;
    rd(0, 2'b11, 12'h005, 0, v);
    rd(1, 2'b11, 12'h006, 0, v);
    @(negedge clk_a);
    rst_n = 1'b0;
    #1;
    chk("R11 async clear A", dout_a, 9'h000, 9'h1FF);
    chk("R11 async clear B", dout_b, 9'h000, 9'h1FF);
    repeat (3) @(negedge clk_a);
    rst_n = 1'b1;
    rd(1, 2'b11, 12'h005, 0, v); chk("R11 contents kept", v, 9'h1A5, 9'h1FF);
  endtask

  task automatic t_concurrent;
    logic [8:0] va, vb;
    fork
      wr(0, 2'b11, 12'd20, 9'h111);
      wr(1, 2'b11, 12'd21, 9'h0EE);
    join
    fork
      rd(0, 2'b11, 12'd21, 0, va);
      rd(1, 2'b11, 12'd20, 0, vb);
    join
    chk("R12 A sees B write", va, 9'h0EE, 9'h1FF);
    chk("R12 B sees A write", vb, 9'h111, 9'h1FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_a);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk_b);
    t_full_width();
    t_narrow_mix();
    t_addr_high();
    t_din_high();
    t_enable();
    t_pipe();
    t_write_modes();
    t_reset_mid();
    t_concurrent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule